// File: doc/BRIEF.md
# Register-Mapped Command Channel Controller

This block is a single host-facing command channel through which software issues one register read or one register write to an external power-management device at a time. The host sees six 32-bit registers on a simple write/read bus: a write-data register, a command register, a read-data register, a ready/clear register, a status register and an init-done register. The downstream side is a generic request/acknowledge port toward a serial bus engine. The engine receives the decoded command fields and returns up to `MAX_BYTES` bytes of read data when it acknowledges.

A small state machine tracks each transaction, and the host can poll its state in the status register. To issue a write, the host loads the write-data register and then writes the command word. To issue a read, the host writes the command word and polls until the state reaches the wait-for-valid-clear value. It then reads the read-data register and writes 1 to the ready register, which releases the channel back to idle.

The registers sit at these byte offsets: 0x00 write data, 0x04 command, 0x08 read data, 0x0C ready/clear, 0x10 status and 0x14 init-done. Only bits [4:2] of the bus address are decoded. Reading the command register returns the last accepted command word. Reading the ready register returns zero.

Top module: `cmd_channel_ctrl`

## Requirements
- R1: The command word is decoded as follows. Bits [31:30] are the opcode and bit 29 is the write flag (1 = write). The slave ID starts at bit 24 (`SID_W` bits). The byte-count field starts at bit 16 (`BC_W` bits) and holds the transfer length minus one. The register address occupies bits [`ADDR_W`-1:0]. The request outputs present exactly these fields.
- R2: A command-register write is accepted only when the state is IDLE and init-done is set. On acceptance, `req_o` is high from the next cycle and the state reads BUSY.
- R3: A command-register write while the state is not IDLE is ignored: the request fields are unchanged, and the sticky error bit (status bit 0) is set.
- R4: A command-register write before init-done is set is rejected. The state stays IDLE, `req_o` stays low, and the error bit is set.
- R5: The error bit is cleared by the next accepted command.
- R6: While `req_o` is high and `ack_i` is low, all request fields, including the write data, stay stable. The write data is the write-data register value at the moment of acceptance, and later writes to that register do not alter it.
- R7: When a write is acknowledged, the state returns directly from BUSY to IDLE.
- R8: When a read is acknowledged, the state moves to WFVLDCLR. The read-data register then holds the returned bytes, little-endian (first byte in bits [7:0]), for the byte count plus one bytes. All other bits read as zero.
- R9: Writing the ready register with bit 0 = 1 in WFVLDCLR returns the state to IDLE. A write with bit 0 = 0, or a ready write in any other state, has no effect. The read data stays held after the clear.
- R10: The status register reads the state in bits [3:1], encoded IDLE=0, BUSY=1 and WFVLDCLR=2. It reads the error bit in bit 0, and its other bits read zero. Init-done register bit 0 mirrors `init_done_i` one cycle late.
- R11: After reset, the state is IDLE, the error bit is 0, `req_o` is low, and the read-data and write-data registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Controller initialisation finished |
| bus_addr_i | input | BUS_AW | Host register byte address |
| bus_we_i | input | 1 | Host register write strobe |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data (combinational from address) |
| req_o | output | 1 | Request to the device engine |
| req_opc_o | output | 2 | Request opcode |
| req_we_o | output | 1 | Request is a write |
| req_sid_o | output | SID_W | Slave ID |
| req_bc_o | output | BC_W | Byte count minus one |
| req_addr_o | output | ADDR_W | Device register address |
| req_wdata_o | output | 32 | Write data |
| ack_i | input | 1 | Device engine acknowledge |
| rsp_data_i | input | MAX_BYTES*8 | Returned read bytes, first byte lowest |

## Verification
The bench uses the default parameters: `ADDR_W` = 16, `SID_W` = 4, `MAX_BYTES` = 2 and `BUS_AW` = 5. With a two-byte maximum, the byte-count field is one bit wide, so random command words reach both the one-byte and the two-byte read packing. The 16-bit address and 4-bit slave ID keep every command field in its own bits, so a field misplaced by the decode shows up in the request outputs. Random transactions mix reads and writes, with commands injected while busy, ready writes with bit 0 clear, and varying acknowledge delays.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_BUSY     = 3'd1,
    ST_WFVLDCLR = 3'd2
  } ch_state_e;

  // register word indices (byte address bits [4:2])
  localparam logic [2:0] REG_WDATA  = 3'd0;
  localparam logic [2:0] REG_CMD    = 3'd1;
  localparam logic [2:0] REG_RDATA  = 3'd2;
  localparam logic [2:0] REG_RDY    = 3'd3;
  localparam logic [2:0] REG_STATUS = 3'd4;
  localparam logic [2:0] REG_INIT   = 3'd5;

  // command word field positions
  localparam int OPC_LSB = 30;
  localparam int WE_BIT  = 29;
  localparam int SID_LSB = 24;
  localparam int BC_LSB  = 16;

endpackage

// File: rtl/ccc_cmd_unpack.sv
module ccc_cmd_unpack
  import ccc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SID_W  = 4,
  parameter int BC_W   = 1
) (
  input  logic [31:0]       cmd_i,
  output logic [1:0]        opc_o,
  output logic              we_o,
  output logic [SID_W-1:0]  sid_o,
  output logic [BC_W-1:0]   bc_o,
  output logic [ADDR_W-1:0] addr_o
);

  assign opc_o  = cmd_i[OPC_LSB +: 2];
  assign we_o   = cmd_i[WE_BIT];
  assign sid_o  = cmd_i[SID_LSB +: SID_W];
  assign bc_o   = cmd_i[BC_LSB +: BC_W];
  assign addr_o = cmd_i[ADDR_W-1:0];

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^cmd_i;

endmodule

// File: rtl/ccc_fsm.sv
module ccc_fsm
  import ccc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_wr_i,
  input  logic      init_ok_i,
  input  logic      clr_wr_i,
  input  logic      ack_i,
  input  logic      is_write_i,
  output ch_state_e state_o,
  output logic      accept_o,
  output logic      reject_o,
  output logic      rd_done_o
);

  ch_state_e state_q, state_d;

  assign accept_o  = cmd_wr_i && (state_q == ST_IDLE) && init_ok_i;
  assign reject_o  = cmd_wr_i && !accept_o;
  assign rd_done_o = (state_q == ST_BUSY) && ack_i && !is_write_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept_o) state_d = ST_BUSY;
      ST_BUSY:     if (ack_i) state_d = is_write_i ? ST_IDLE : ST_WFVLDCLR;
      ST_WFVLDCLR: if (clr_wr_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/ccc_rsp_pack.sv
module ccc_rsp_pack #(
  parameter int MAX_BYTES = 2,
  parameter int BC_W      = 1
) (
  input  logic [MAX_BYTES*8-1:0] rsp_i,
  input  logic [BC_W-1:0]        bc_i,
  output logic [31:0]            data_o
);

  logic [31:0] bc_ext;
  assign bc_ext = {{(32-BC_W){1'b0}}, bc_i};

  for (genvar i = 0; i < 4; i++) begin : g_byte
    if (i < MAX_BYTES) begin : g_live
      assign data_o[8*i +: 8] = (bc_ext >= 32'(i)) ? rsp_i[8*i +: 8] : 8'h00;
    end else begin : g_zero
      assign data_o[8*i +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/cmd_channel_ctrl.sv
module cmd_channel_ctrl
  import ccc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SID_W     = 4,
  parameter int MAX_BYTES = 2,
  parameter int BUS_AW    = 5,
  localparam int BC_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   init_done_i,
  input  logic [BUS_AW-1:0]      bus_addr_i,
  input  logic                   bus_we_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  output logic                   req_o,
  output logic [1:0]             req_opc_o,
  output logic                   req_we_o,
  output logic [SID_W-1:0]       req_sid_o,
  output logic [BC_W-1:0]        req_bc_o,
  output logic [ADDR_W-1:0]      req_addr_o,
  output logic [31:0]            req_wdata_o,
  input  logic                   ack_i,
  input  logic [MAX_BYTES*8-1:0] rsp_data_i
);

  localparam int IDX_W = BUS_AW - 2;

  logic [IDX_W-1:0] reg_idx;
  assign reg_idx = bus_addr_i[BUS_AW-1:2];

  logic wr_wdata, wr_cmd, wr_clr;
  assign wr_wdata = bus_we_i && (reg_idx == IDX_W'(REG_WDATA));
  assign wr_cmd   = bus_we_i && (reg_idx == IDX_W'(REG_CMD));
  assign wr_clr   = bus_we_i && (reg_idx == IDX_W'(REG_RDY)) && bus_wdata_i[0];

  logic [31:0] wdata_q, cmd_q, rdata_q, wdata_lat_q;
  logic        err_q, init_q;

  ch_state_e state;
  logic      accept, reject, rd_done;

  ccc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (wr_cmd),
    .init_ok_i  (init_q),
    .clr_wr_i   (wr_clr),
    .ack_i      (ack_i),
    .is_write_i (req_we_o),
    .state_o    (state),
    .accept_o   (accept),
    .reject_o   (reject),
    .rd_done_o  (rd_done)
  );

  ccc_cmd_unpack #(
    .ADDR_W (ADDR_W),
    .SID_W  (SID_W),
    .BC_W   (BC_W)
  ) u_unpack (
    .cmd_i  (cmd_q),
    .opc_o  (req_opc_o),
    .we_o   (req_we_o),
    .sid_o  (req_sid_o),
    .bc_o   (req_bc_o),
    .addr_o (req_addr_o)
  );

  logic [31:0] rsp_packed;

  ccc_rsp_pack #(
    .MAX_BYTES (MAX_BYTES),
    .BC_W      (BC_W)
  ) u_pack (
    .rsp_i  (rsp_data_i),
    .bc_i   (req_bc_o),
    .data_o (rsp_packed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q     <= '0;
      cmd_q       <= '0;
      rdata_q     <= '0;
      wdata_lat_q <= '0;
      err_q       <= 1'b0;
      init_q      <= 1'b0;
    end else begin
      init_q <= init_done_i;
      if (wr_wdata) wdata_q <= bus_wdata_i;
      if (accept) begin
        cmd_q       <= bus_wdata_i;
        wdata_lat_q <= wdata_q;
        err_q       <= 1'b0;
      end else if (reject) begin
        err_q <= 1'b1;
      end
      if (rd_done) rdata_q <= rsp_packed;
    end
  end

  assign req_o       = (state == ST_BUSY);
  assign req_wdata_o = wdata_lat_q;

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_idx)
      IDX_W'(REG_WDATA):  bus_rdata_o = wdata_q;
      IDX_W'(REG_CMD):    bus_rdata_o = cmd_q;
      IDX_W'(REG_RDATA):  bus_rdata_o = rdata_q;
      IDX_W'(REG_STATUS): bus_rdata_o = {28'd0, state, err_q};
      IDX_W'(REG_INIT):   bus_rdata_o = {31'd0, init_q};
      default:            bus_rdata_o = '0;
    endcase
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^bus_addr_i[1:0];

endmodule

// File: rtl/cmd_channel_ctrl_sva.sv
module cmd_channel_ctrl_sva #(
  parameter int ADDR_W = 16,
  parameter int SID_W  = 4,
  parameter int BC_W   = 1,
  parameter int BUS_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [31:0]       bus_wdata_i,
  input logic              req_o,
  input logic              req_we_o,
  input logic [1:0]        req_opc_o,
  input logic [SID_W-1:0]  req_sid_o,
  input logic [BC_W-1:0]   req_bc_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [31:0]       req_wdata_o,
  input logic              ack_i,
  input logic [2:0]        state_i,
  input logic              err_i,
  input logic              init_i
);

  logic cmd_wr, clr_wr;
  assign cmd_wr = bus_we_i && (bus_addr_i[BUS_AW-1:2] == (BUS_AW-2)'(1));
  assign clr_wr = bus_we_i && (bus_addr_i[BUS_AW-1:2] == (BUS_AW-2)'(3)) && bus_wdata_i[0];

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && state_i == 3'd0 && init_i) |=> (req_o && state_i == 3'd1));

  assert_err_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && state_i == 3'd0 && init_i) |=> !err_i);

  assert_reject_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && state_i != 3'd0) |=> (err_i && $stable(req_addr_o) && $stable(req_sid_o)
                                     && $stable(req_opc_o) && $stable(req_bc_o)));

  assert_reject_init_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && state_i == 3'd0 && !init_i) |=> (err_i && !req_o));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(req_addr_o) && $stable(req_sid_o)
                           && $stable(req_opc_o) && $stable(req_bc_o)
                           && $stable(req_we_o) && $stable(req_wdata_o)));

  assert_write_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && req_we_o) |=> (state_i == 3'd0));

  assert_read_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && !req_we_o) |=> (state_i == 3'd2));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd2 && clr_wr) |=> (state_i == 3'd0));

  assert_wait_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd2 && !clr_wr) |=> (state_i == 3'd2));

  assert_state_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i <= 3'd2);

endmodule

bind cmd_channel_ctrl cmd_channel_ctrl_sva #(
  .ADDR_W (ADDR_W),
  .SID_W  (SID_W),
  .BC_W   (BC_W),
  .BUS_AW (BUS_AW)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .req_o       (req_o),
  .req_we_o    (req_we_o),
  .req_opc_o   (req_opc_o),
  .req_sid_o   (req_sid_o),
  .req_bc_o    (req_bc_o),
  .req_addr_o  (req_addr_o),
  .req_wdata_o (req_wdata_o),
  .ack_i       (ack_i),
  .state_i     (state),
  .err_i       (err_q),
  .init_i      (init_q)
);

// File: tb/cmd_channel_ctrl_bench.sv
module cmd_channel_ctrl_bench;

  localparam int ADDR_W = 16;
  localparam int SID_W = 4;
  localparam int MAX_BYTES = 2;
  localparam int BUS_AW = 5;
  localparam int BC_W = 1;

  localparam logic [4:0] A_WDATA = 5'h00, A_CMD = 5'h04, A_RDATA = 5'h08,
                         A_RDY = 5'h0C, A_STAT = 5'h10, A_INIT = 5'h14;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic init_done_i = 1'b0;
  logic [BUS_AW-1:0] bus_addr_i = '0;
  logic bus_we_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic req_o, req_we_o;
  logic [1:0] req_opc_o;
  logic [SID_W-1:0] req_sid_o;
  logic [BC_W-1:0] req_bc_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [31:0] req_wdata_o;
  logic ack_i = 1'b0;
  logic [MAX_BYTES*8-1:0] rsp_data_i = '0;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  cmd_channel_ctrl #(
    .ADDR_W(ADDR_W), .SID_W(SID_W), .MAX_BYTES(MAX_BYTES), .BUS_AW(BUS_AW)
  ) u_cmd_channel_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_done_i(init_done_i),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .req_o(req_o), .req_opc_o(req_opc_o),
    .req_we_o(req_we_o), .req_sid_o(req_sid_o), .req_bc_o(req_bc_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o), .ack_i(ack_i),
    .rsp_data_i(rsp_data_i)
  );

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_cmd(input logic [1:0] opc, input logic we,
                                           input logic [3:0] sid, input logic bc,
                                           input logic [15:0] addr);
    return {opc, we, 1'b0, sid, 7'd0, bc, addr};
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [15:0] rsp, input logic bc);
    return bc ? {16'd0, rsp} : {24'd0, rsp[7:0]};
  endfunction

  function automatic logic [31:0] exp_stat(input logic [2:0] st, input logic err);
    return {28'd0, st, err};
  endfunction

  // drive at negedge, return at the following negedge
  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr_i = a; #1; d = bus_rdata_o;
  endtask

  task automatic dev_ack(input logic [15:0] rsp);
    ack_i = 1'b1; rsp_data_i = rsp;
    @(posedge clk_i); @(negedge clk_i);
    ack_i = 1'b0; rsp_data_i = '0;
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] cw, wd;
    logic [15:0] rsp;
    logic exp_err;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk_i);
    bus_rd(A_STAT, rd); chk("R11 status in reset", rd, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 req_o after reset", {31'd0, req_o}, 32'd0);
    bus_rd(A_RDATA, rd); chk("R11 rdata after reset", rd, 32'd0);
    bus_rd(A_WDATA, rd); chk("R11 wdata after reset", rd, 32'd0);
    bus_rd(A_INIT, rd); chk("R10 init low", rd, 32'd0);

    // command before init
    bus_wr(A_CMD, pack_cmd(2'd1, 1'b0, 4'd3, 1'b0, 16'h1234));
    chk("R4 no request before init", {31'd0, req_o}, 32'd0);
    bus_rd(A_STAT, rd); chk("R4 idle+err before init", rd, exp_stat(3'd0, 1'b1));

    init_done_i = 1'b1;
    @(negedge clk_i);
    bus_rd(A_INIT, rd); chk("R10 init mirrored", rd, 32'd1);

    // ready write while idle: no effect
    bus_wr(A_RDY, 32'd1);
    bus_rd(A_STAT, rd); chk("R9 rdy in idle ignored", rd, exp_stat(3'd0, 1'b1));

    // directed two-byte read
    bus_wr(A_CMD, pack_cmd(2'd2, 1'b0, 4'hA, 1'b1, 16'hBEEF));
    chk("R2 req_o after accept", {31'd0, req_o}, 32'd1);
    chk("R1 addr", {16'd0, req_addr_o}, 32'h0000BEEF);
    chk("R1 sid", {28'd0, req_sid_o}, 32'hA);
    chk("R1 opc", {30'd0, req_opc_o}, 32'd2);
    chk("R1 bc", {31'd0, req_bc_o}, 32'd1);
    bus_rd(A_STAT, rd); chk("R5 err cleared on accept", rd, exp_stat(3'd1, 1'b0));
    dev_ack(16'hC35A);
    bus_rd(A_STAT, rd); chk("R8 wait state", rd, exp_stat(3'd2, 1'b0));
    bus_rd(A_RDATA, rd); chk("R8 two-byte little-endian", rd, 32'h0000C35A);
    bus_wr(A_CMD, pack_cmd(2'd0, 1'b1, 4'd1, 1'b0, 16'h0001));
    bus_rd(A_STAT, rd); chk("R3 cmd in wait rejected", rd, exp_stat(3'd2, 1'b1));
    chk("R3 addr unchanged", {16'd0, req_addr_o}, 32'h0000BEEF);
    bus_wr(A_RDY, 32'd1);
    bus_rd(A_STAT, rd); chk("R9 cleared to idle", rd, exp_stat(3'd0, 1'b1));
    bus_rd(A_RDATA, rd); chk("R9 rdata held after clear", rd, 32'h0000C35A);
    exp_err = 1'b1;

    for (int it = 0; it < 60; it++) begin
      logic [1:0] opc;
      logic we, bc;
      logic [3:0] sid;
      logic [15:0] addr;
      opc = 2'($urandom); we = 1'($urandom); bc = 1'($urandom);
      sid = 4'($urandom); addr = 16'($urandom); wd = $urandom; rsp = 16'($urandom);
      cw = pack_cmd(opc, we, sid, bc, addr);

      bus_wr(A_WDATA, wd);
      bus_wr(A_CMD, cw);
      exp_err = 1'b0;
      chk("R2 request raised", {31'd0, req_o}, 32'd1);
      chk("R1 request fields", {req_opc_o, req_we_o, 1'b0, req_sid_o, 7'd0, req_bc_o, req_addr_o}, cw);
      chk("R6 write data latched", req_wdata_o, wd);
      bus_rd(A_CMD, rd); chk("R1 cmd readback", rd, cw);

      if ($urandom_range(2) == 0) begin
        bus_wr(A_CMD, ~cw);
        exp_err = 1'b1;
        bus_rd(A_STAT, rd); chk("R3 busy reject", rd, exp_stat(3'd1, 1'b1));
        chk("R3 fields unchanged", {req_opc_o, req_we_o, 1'b0, req_sid_o, 7'd0, req_bc_o, req_addr_o}, cw);
        bus_wr(A_WDATA, ~wd);
        chk("R6 wdata held during request", req_wdata_o, wd);
      end

      repeat ($urandom_range(3)) @(negedge clk_i);
      chk("R6 request held until ack", {31'd0, req_o}, 32'd1);
      dev_ack(rsp);
      chk("R6 request dropped after ack", {31'd0, req_o}, 32'd0);

      if (we) begin
        bus_rd(A_STAT, rd); chk("R7 write back to idle", rd, exp_stat(3'd0, exp_err));
      end else begin
        bus_rd(A_STAT, rd); chk("R8 read in wait state", rd, exp_stat(3'd2, exp_err));
        bus_rd(A_RDATA, rd); chk("R8 read data packing", rd, exp_rdata(rsp, bc));
        if ($urandom_range(1) == 0) begin
          bus_wr(A_RDY, 32'hFFFF_FFFE);
          bus_rd(A_STAT, rd); chk("R9 bit0 clear ignored", rd, exp_stat(3'd2, exp_err));
        end
        bus_wr(A_RDY, 32'd1);
        bus_rd(A_STAT, rd); chk("R9 clear to idle", rd, exp_stat(3'd0, exp_err));
        bus_rd(A_RDATA, rd); chk("R9 data held", rd, exp_rdata(rsp, bc));
      end
    end

    report();
  end

endmodule